// File: doc/BRIEF.md
# Paged program sequencer with skip

This block steers instruction fetch for a small 4-bit controller. It keeps a 10-bit fetch address made of a 4-bit page and a 6-bit offset within the page. It also keeps a two-level return stack and a skip flag. An external decoder presents, for each word fetched at `fetch_addr_o`, what kind of flow change that word requests. It also presents the word's immediate byte, a run class for the self-skipping load instructions, and a request to arm the skip flag. The block answers on the same cycle with `nop_o`, which tells the executor to treat the word as a no-operation. On the clock edge it moves to the next fetch address.

Short jumps and short calls replace only the offset and stay inside the current page. Long jumps and long calls take two words: the first word supplies the upper two address bits, and the second word, fetched from the next address, supplies the low eight bits. Returns pop the stack. On overflow the oldest entry is lost, and on underflow the deepest entry is reused.

The fetch side has no back-pressure: `op_valid_i` qualifies a consumed word. When it is low, no state moves, and the same address stays presented.

Top module: `page_seq`

## Requirements
- R1: After reset the fetch address is 000h, `word2_o` is 0, `nop_o` is 0, the skip flag is clear, and both stack levels hold 000h.
- R2: A consumed word of kind 0 (sequential), or of an unused kind code 6 or 7, advances the full 10-bit address by one, wrapping from 3FFh to 000h. While `op_valid_i` is low, no state changes.
- R3: Kind 1 (short jump) loads `op_imm_i[5:0]` into the offset and keeps the page.
- R4: Kind 2 (short call) pushes the call word's address plus one, then loads `op_imm_i[5:0]` into the offset and keeps the page.
- R5: Kind 3 (long jump) takes `op_imm_i[1:0]` as address bits 9:8 and advances by one. The next consumed word is a second word, flagged by `word2_o`=1, whose `op_imm_i[7:0]` becomes address bits 7:0. That second word then loads the full address; its kind code is ignored.
- R6: Kind 4 (long call) behaves like a long jump. In addition, when its second word is consumed, it pushes the first word's address plus two.
- R7: A push moves level 1 into level 2 and writes the return address into level 1, so after three nested calls only the latest two return addresses remain.
- R8: Kind 5 (return) loads level 1 into the fetch address and copies level 2 into level 1 while level 2 keeps its value, so extra returns keep yielding the old level-2 address.
- R9: `skip_set_i` on a consumed word that is not a no-operation arms the skip flag. The next first word then gets `nop_o`=1, advances the address by one without touching the stack, whatever its kind, and clears the flag. `skip_set_i` on a no-operation word is ignored.
- R10: When the first word of a long jump or long call is a no-operation, its second word is a no-operation too. Together the two words advance the address by two and leave the stack unchanged.
- R11: `run_class_i` marks self-skipping loads: 0 means none, 1 an accumulator immediate load, 2 an L immediate load, and 3 a set or clear of H. A first word whose nonzero class equals the class of the previous first word gets `nop_o`=1 without using the skip flag. Every first word records its class, even when it is a no-operation; second words leave the recorded class alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | The word at `fetch_addr_o` is consumed on this edge |
| op_kind_i | input | 3 | Flow kind of the word: 0 sequential, 1 short jump, 2 short call, 3 long jump, 4 long call, 5 return |
| op_imm_i | input | 8 | Immediate byte of the word (offset, upper address bits, or low address byte) |
| run_class_i | input | 2 | Self-skipping load class of the word, 0 for none |
| skip_set_i | input | 1 | The word's condition holds; arm the skip flag |
| fetch_addr_o | output | 10 | Address of the word to fetch |
| word2_o | output | 1 | The presented word is the second word of a long instruction |
| nop_o | output | 1 | The presented word must be executed as a no-operation |

## Verification
On every cycle, the assertions check several things: that the stack shifts by one level on push and on pop, that a stalled cycle holds the address, and that a short jump keeps the page. They also check that a no-operation first word only increments the address, and that the skip flag rises only from a request. The bench's scenarios are needed for the sequences that span several instructions. These are the overflow that drops a return address, repeated returns past the stack depth, a skipped long call that leaves the stack untouched, the wrap from the last address to zero, and runs of self-skipping loads broken by a different class.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // flow kind presented with every first word
  typedef enum logic [2:0] {
    KIND_SEQ  = 3'd0,
    KIND_JMP  = 3'd1,
    KIND_CAL  = 3'd2,
    KIND_LJMP = 3'd3,
    KIND_LCAL = 3'd4,
    KIND_RET  = 3'd5
  } pseq_kind_e;

  localparam int CLS_W = 2;
  localparam logic [CLS_W-1:0] CLS_NONE = '0;
endpackage

// File: rtl/pseq_stack.sv
module pseq_stack #(
  parameter int AW    = 10,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [AW-1:0] lvl_q [DEPTH];

  // push shifts down and drops the deepest entry; pop shifts up and keeps the deepest entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (push_i) begin
      lvl_q[0] <= push_data_i;
      for (int i = 1; i < DEPTH; i++) lvl_q[i] <= lvl_q[i-1];
    end else if (pop_i) begin
      for (int i = 0; i < DEPTH-1; i++) lvl_q[i] <= lvl_q[i+1];
    end
  end

  assign top_o = lvl_q[0];

  assert_push_pop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i)) else $error("push and pop together");

  assert_push_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(push_data_i)) else $error("push lost");

  if (DEPTH > 1) begin : g_deep
    assert_push_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> lvl_q[1] == $past(lvl_q[0])) else $error("push shift");
    assert_pop_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> lvl_q[0] == $past(lvl_q[1])) else $error("pop shift");
    assert_pop_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-1])) else $error("pop deepest");
  end
endmodule

// File: rtl/pseq_skip.sv
module pseq_skip
  import pseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             word2_i,
  input  logic [CLS_W-1:0] run_class_i,
  input  logic             skip_set_i,
  output logic             nop_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             sf_q;       // skip flag
  logic             skip2_q;    // first word of the long op was a no-operation
  logic [CLS_W-1:0] last_cls_q; // class of the previous first word
  logic             run_hit;

  assign run_hit = (run_class_i != CLS_NONE) && (run_class_i == last_cls_q);
  assign nop_o   = word2_i ? skip2_q : (sf_q || run_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q       <= 1'b0;
      skip2_q    <= 1'b0;
      last_cls_q <= CLS_NONE;
    end else if (valid_i) begin
      sf_q <= nop_o ? 1'b0 : skip_set_i;
      if (!word2_i) begin
        skip2_q    <= nop_o;
        last_cls_q <= run_class_i;
      end
    end
  end

  assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sf_q) |-> $past(valid_i && skip_set_i)) else $error("flag set without request");

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !word2_i && nop_o) |=> !sf_q) else $error("flag survived skip");

  assert_class_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && word2_i) |=> $stable(last_cls_q)) else $error("second word changed class");
endmodule

// File: rtl/pseq_pc.sv
module pseq_pc
  import pseq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 6,
  parameter int WORD_W = 8,
  localparam int AW    = PAGE_W + OFS_W,
  localparam int HI_W  = AW - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        kind_i,
  input  logic [WORD_W-1:0] imm_i,
  input  logic              nop_i,
  input  logic [AW-1:0]     stack_top_i,
  output logic [AW-1:0]     pc_o,
  output logic              word2_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [AW-1:0]     push_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  pseq_kind_e      kind;
  logic [AW-1:0]   pc_q, pc_d, pc_inc;
  logic            w2_q, w2_d;
  logic [HI_W-1:0] lhi_q, lhi_d;
  logic            lcall_q, lcall_d;
  logic            is_long;

  assign kind    = pseq_kind_e'(kind_i);
  assign pc_inc  = pc_q + 1'b1;
  assign is_long = (kind == KIND_LJMP) || (kind == KIND_LCAL);

  always_comb begin
    pc_d        = pc_q;
    w2_d        = w2_q;
    lhi_d       = lhi_q;
    lcall_d     = lcall_q;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    push_data_o = pc_inc;
    if (valid_i) begin
      if (w2_q) begin
        w2_d = 1'b0;
        if (nop_i) begin
          pc_d = pc_inc;
        end else begin
          pc_d = {lhi_q, imm_i};
          push_o = lcall_q;       // pc_q is first word + 1 here
        end
      end else if (nop_i) begin
        pc_d = pc_inc;
        w2_d = is_long;
      end else begin
        case (kind)
          KIND_JMP: pc_d = {pc_q[AW-1:OFS_W], imm_i[OFS_W-1:0]};
          KIND_CAL: begin
            push_o = 1'b1;
            pc_d   = {pc_q[AW-1:OFS_W], imm_i[OFS_W-1:0]};
          end
          KIND_LJMP, KIND_LCAL: begin
            w2_d    = 1'b1;
            lhi_d   = imm_i[HI_W-1:0];
            lcall_d = (kind == KIND_LCAL);
            pc_d    = pc_inc;
          end
          KIND_RET: begin
            pop_o = 1'b1;
            pc_d  = stack_top_i;
          end
          default: pc_d = pc_inc;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      w2_q    <= 1'b0;
      lhi_q   <= '0;
      lcall_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      w2_q    <= w2_d;
      lhi_q   <= lhi_d;
      lcall_q <= lcall_d;
    end
  end

  assign pc_o    = pc_q;
  assign word2_o = w2_q;

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(pc_q) && $stable(w2_q)) else $error("stall moved state");

  assert_short_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !w2_q && !nop_i && kind == KIND_JMP) |=>
      pc_q[OFS_W-1:0] == $past(imm_i[OFS_W-1:0]) &&
      pc_q[AW-1:OFS_W] == $past(pc_q[AW-1:OFS_W])) else $error("short jump left page");

  assert_skip_incr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && nop_i) |=> pc_q == $past(pc_inc)) else $error("skipped word moved pc");

  assert_skip_nostack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nop_i |-> !push_o && !pop_o) else $error("skipped word used stack");

  assert_word2_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w2_q) |-> $past(valid_i && is_long)) else $error("second word from nowhere");
endmodule

// File: rtl/page_seq.sv
module page_seq
  import pseq_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int OFS_W       = 6,
  parameter int WORD_W      = 8,
  parameter int STACK_DEPTH = 2,
  localparam int AW         = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [2:0]        op_kind_i,
  input  logic [WORD_W-1:0] op_imm_i,
  input  logic [CLS_W-1:0]  run_class_i,
  input  logic              skip_set_i,
  output logic [AW-1:0]     fetch_addr_o,
  output logic              word2_o,
  output logic              nop_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic          push, pop;
  logic [AW-1:0] push_data, stack_top;

  pseq_skip u_skip (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (op_valid_i),
    .word2_i     (word2_o),
    .run_class_i (run_class_i),
    .skip_set_i  (skip_set_i),
    .nop_o       (nop_o)
  );

  pseq_pc #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .WORD_W(WORD_W)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (op_valid_i),
    .kind_i      (op_kind_i),
    .imm_i       (op_imm_i),
    .nop_i       (nop_o),
    .stack_top_i (stack_top),
    .pc_o        (fetch_addr_o),
    .word2_o     (word2_o),
    .push_o      (push),
    .pop_o       (pop),
    .push_data_o (push_data)
  );

  pseq_stack #(.AW(AW), .DEPTH(STACK_DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (push_data),
    .top_o       (stack_top)
  );

  assert_ret_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> fetch_addr_o == $past(stack_top)) else $error("return target");
endmodule

// File: tb/page_seq_bench.sv
module page_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;
  import pseq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [2:0] op_kind_i = '0;
  logic [7:0] op_imm_i = '0;
  logic [1:0] run_class_i = '0;
  logic       skip_set_i = 1'b0;
  logic [9:0] fetch_addr_o;
  logic       word2_o, nop_o;

  always #5 clk = ~clk;

  page_seq u_page_seq (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_kind_i(op_kind_i),
    .op_imm_i(op_imm_i), .run_class_i(run_class_i), .skip_set_i(skip_set_i),
    .fetch_addr_o(fetch_addr_o), .word2_o(word2_o), .nop_o(nop_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [9:0] m_pc = '0;
  logic [9:0] m_stk [2] = '{10'h0, 10'h0};
  logic       m_sf = 0, m_w2 = 0, m_skip2 = 0, m_lc = 0;
  logic [1:0] m_hi = 0, m_last = 0;

  logic [9:0] exp_addr [$];
  string      exp_tag  [$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_push(logic [9:0] v);
    m_stk[1] = m_stk[0];
    m_stk[0] = v;
  endtask

  // scoreboard driver: drive one word, check nop at once, queue the next address
  task automatic step(logic [2:0] kind, logic [7:0] imm, logic [1:0] cls, bit sk, string tag);
    logic       nop_e;
    logic [9:0] nxt;
    @(negedge clk);
    op_valid_i = 1'b1; op_kind_i = kind; op_imm_i = imm;
    run_class_i = cls; skip_set_i = sk;
    #1;
    nop_e = m_w2 ? m_skip2 : (m_sf || (cls != 0 && cls == m_last));
    chk(nop_o == nop_e, tag, "nop_o", nop_o, nop_e);
    chk(word2_o == m_w2, tag, "word2_o", word2_o, m_w2);
    nxt = m_pc + 10'd1;
    if (m_w2) begin
      if (!m_skip2) begin
        nxt = {m_hi, imm};
        if (m_lc) m_push(m_pc + 10'd1);
      end
      m_w2 = 0;
    end else begin
      m_last  = cls;
      m_skip2 = nop_e;
      if (nop_e) begin
        m_w2 = (kind == KIND_LJMP || kind == KIND_LCAL);
      end else begin
        case (kind)
          KIND_JMP: nxt = {m_pc[9:6], imm[5:0]};
          KIND_CAL: begin m_push(m_pc + 10'd1); nxt = {m_pc[9:6], imm[5:0]}; end
          KIND_LJMP, KIND_LCAL: begin
            m_w2 = 1; m_hi = imm[1:0]; m_lc = (kind == KIND_LCAL);
          end
          KIND_RET: begin nxt = m_stk[0]; m_stk[0] = m_stk[1]; end
          default: ;
        endcase
      end
    end
    m_sf = nop_e ? 1'b0 : sk;
    m_pc = nxt;
    @(posedge clk);
    exp_addr.push_back(nxt);
    exp_tag.push_back(tag);
  endtask

  // monitor: compare the address produced by each consumed word
  always @(negedge clk) begin
    if (exp_addr.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_addr.pop_front();
      t = exp_tag.pop_front();
      chk(fetch_addr_o == e, t, "fetch_addr_o", fetch_addr_o, e);
    end
  end

  task automatic stall(int n, string tag);
    @(negedge clk);
    op_valid_i = 1'b0; skip_set_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(fetch_addr_o == m_pc, tag, "held address", fetch_addr_o, m_pc);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_addr_o == 10'h000, "R1", "reset address", fetch_addr_o, 0);
    chk(word2_o == 1'b0, "R1", "reset word2", word2_o, 0);
    chk(nop_o == 1'b0, "R1", "reset nop", nop_o, 0);

    // R2 sequential and stall; unused kind 7 counts as sequential
    step(KIND_SEQ, 8'h00, 0, 0, "R2");
    step(KIND_SEQ, 8'hFF, 0, 0, "R2");
    step(3'd7, 8'h12, 0, 0, "R2");
    stall(3, "R2");
    // R3 short jump in page 0
    step(KIND_JMP, 8'hEA, 0, 0, "R3");
    // R5 long jump to 1C5h, then short jump inside page 7
    step(KIND_LJMP, 8'h01, 0, 0, "R5");
    step(KIND_RET, 8'hC5, 0, 0, "R5");
    step(KIND_JMP, 8'h3F, 0, 0, "R3");
    step(KIND_SEQ, 8'h00, 0, 0, "R2");
    // R4 short call, R6 long call, R7 third call drops the oldest
    step(KIND_CAL, 8'h10, 0, 0, "R4");
    step(KIND_LCAL, 8'h03, 0, 0, "R6");
    step(KIND_SEQ, 8'h80, 0, 0, "R6");
    step(KIND_CAL, 8'h05, 0, 0, "R7");
    // R8 returns, the last one reuses level 2
    step(KIND_RET, 8'h00, 0, 0, "R8");
    step(KIND_RET, 8'h00, 0, 0, "R8");
    step(KIND_RET, 8'h00, 0, 0, "R8");
    // R9 skipped short call, then return proves the stack untouched
    step(KIND_SEQ, 8'h00, 0, 1, "R9");
    step(KIND_CAL, 8'h01, 0, 0, "R9");
    step(KIND_RET, 8'h00, 0, 0, "R9");
    // R9 request on a skipped word is ignored
    step(KIND_SEQ, 8'h00, 0, 1, "R9");
    step(KIND_SEQ, 8'h00, 0, 1, "R9");
    step(KIND_SEQ, 8'h00, 0, 0, "R9");
    // R10 skipped long call, both words, stack unchanged
    step(KIND_SEQ, 8'h00, 0, 1, "R10");
    step(KIND_LCAL, 8'h02, 0, 0, "R10");
    step(KIND_SEQ, 8'h44, 0, 0, "R10");
    step(KIND_RET, 8'h00, 0, 0, "R10");
    // R11 runs of self-skipping loads
    step(KIND_SEQ, 8'h00, 1, 0, "R11");
    step(KIND_SEQ, 8'h00, 1, 0, "R11");
    step(KIND_SEQ, 8'h00, 1, 0, "R11");
    step(KIND_SEQ, 8'h00, 2, 0, "R11");
    step(KIND_SEQ, 8'h00, 3, 0, "R11");
    step(KIND_JMP, 8'h20, 3, 0, "R11");
    step(KIND_SEQ, 8'h00, 0, 0, "R11");
    step(KIND_SEQ, 8'h00, 1, 0, "R11");
    // R2 wrap from 3FFh
    step(KIND_LJMP, 8'h03, 0, 0, "R2");
    step(KIND_SEQ, 8'hFF, 0, 0, "R2");
    step(KIND_SEQ, 8'h00, 0, 0, "R2");
    stall(2, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule